// File: doc/BRIEF.md
# Buffered Factory Program Command Controller

This block is the command-interface state machine for a NOR-style flash device's accelerated factory programming mode. Two bus writes open a session: a setup opcode, then a confirm opcode whose address names the start of a 32-word buffer. The block then gathers data words from writes at that start address into an internal buffer. Each time the buffer fills, it hands the buffer to a behavioural array through a start/done handshake. The array pulls the words by index.

Refilling is allowed as often as needed, and each refill targets the next 32-word buffer of the same block. A write to an address in another block ends the session. Any partly filled buffer is programmed first. Protected blocks, misaligned start addresses, a changed address during the session, writes that arrive while a buffer is being programmed, and a wrong confirm cycle are all recorded as sticky bits in an 8-bit status register. Outside a session, reads return array data unless status mode was selected.

Top module: `bfp_ctrl`

## Requirements
- R1: The session opens only after a write of the setup opcode (0x0080) followed by a write of the confirm opcode (0x00D0). From the setup write until the session ends, reads return the status register zero-extended: bit 7 = ready, bit 5 = sequence error, bit 4 = program error, bit 3 = overflow, bit 1 = protect abort.
- R2: If the write after the setup opcode is anything other than the confirm opcode, the block returns to array mode, so reads return `arr_rdata`. It also sets status bit 5.
- R3: Once the session is open, every write to the start address is stored as data. This includes the status-read opcode 0x0070, the suspend opcode 0x00B0 and the array-read opcode 0x00FF. The words are delivered to the array in arrival order.
- R4: A confirm at an address whose low 5 bits are not zero sets status bit 4. No program request is issued, and reads return status.
- R5: A confirm into a block whose `blk_prot` bit is set sets status bits 4 and 1. No program request is issued, so the array is left unchanged.
- R6: The 32nd stored word causes exactly one program request with length 32. Status bit 7 reads 0 from that write until `arr_done`.
- R7: After a buffer completes, the session accepts another 32 words at the same start address. Request n (counting from 0) targets start address + 32·n.
- R8: A write that arrives while a buffer is being programmed is dropped and sets the sticky overflow bit 3.
- R9: A write whose address lies in another block ends the session. A pending partial buffer of k words is first programmed with length k. Afterwards reads return array data.
- R10: Error bits stay set until a clear-status write (0x0050) outside a session, which resets bits 1, 3, 4 and 5.
- R11: Outside a session, opcode 0x0070 selects status reads and opcode 0x00FF selects array reads. Reset selects array reads.
- R12: A session write at an address other than the start address, but within the same block, sets status bit 4 and ends the session without a program request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Word address of the bus cycle |
| bus_wdata | input | 16 | Write data / opcode |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 16 | Status register or array data |
| arr_rdata | input | 16 | Array read data |
| blk_prot | input | 64 | Per-block protect flags |
| arr_start | output | 1 | One-cycle program request |
| arr_base | output | 16 | First word address of the request |
| arr_len | output | 6 | Number of words in the request |
| arr_idx | input | 5 | Buffer index the array is reading |
| arr_word | output | 16 | Buffer word at `arr_idx` |
| arr_done | input | 1 | Array finished the request |

## Verification
A wrong phase state shows at the bus port in the cycle after the offending write. Reads switch between array data and status, or bit 7 fails to fall when a buffer is handed over. A wrong fill count or a wrong buffer index shows only at the next program request, either as a request with the wrong length or base, or as words delivered in the wrong order. For that reason the bench compares every captured word and every request header. Sticky-bit faults show on the next status read, and each scenario reads the status before and after clearing it.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SETUP = 2'd1,
    S_FILL  = 2'd2,
    S_PROG  = 2'd3
  } bfp_state_e;

  localparam int SR_READY = 7;
  localparam int SR_SEQ   = 5;
  localparam int SR_PROG  = 4;
  localparam int SR_OVF   = 3;
  localparam int SR_PROT  = 1;
endpackage

// File: rtl/bfp_wbuf.sv
module bfp_wbuf #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (we && waddr == IW'(i)) mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bfp_status.sv
module bfp_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_seq,
  input  logic set_prog,
  input  logic set_ovf,
  input  logic set_prot,
  input  logic clr,
  output logic sr_seq,
  output logic sr_prog,
  output logic sr_ovf,
  output logic sr_prot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_seq  <= 1'b0;
      sr_prog <= 1'b0;
      sr_ovf  <= 1'b0;
      sr_prot <= 1'b0;
    end else if (clr) begin
      sr_seq  <= 1'b0;
      sr_prog <= 1'b0;
      sr_ovf  <= 1'b0;
      sr_prot <= 1'b0;
    end else begin
      if (set_seq)  sr_seq  <= 1'b1;
      if (set_prog) sr_prog <= 1'b1;
      if (set_ovf)  sr_ovf  <= 1'b1;
      if (set_prot) sr_prot <= 1'b1;
    end
  end
endmodule

// File: rtl/bfp_ctrl.sv
module bfp_ctrl #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 32,
  parameter int BLK_AW    = 10,
  parameter logic [15:0] SETUP_OP   = 16'h0080,
  parameter logic [15:0] CONFIRM_OP = 16'h00D0,
  parameter logic [15:0] CLR_OP     = 16'h0050,
  parameter logic [15:0] RDSR_OP    = 16'h0070,
  parameter logic [15:0] RDARR_OP   = 16'h00FF,
  localparam int IW   = $clog2(BUF_WORDS),
  localparam int LW   = IW + 1,
  localparam int BW   = AW - BLK_AW,
  localparam int NBLK = 1 << BW,
  localparam int OW   = AW - IW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  output logic [DW-1:0]   bus_rdata,
  input  logic [DW-1:0]   arr_rdata,
  input  logic [NBLK-1:0] blk_prot,
  output logic            arr_start,
  output logic [AW-1:0]   arr_base,
  output logic [LW-1:0]   arr_len,
  input  logic [IW-1:0]   arr_idx,
  output logic [DW-1:0]   arr_word,
  input  logic            arr_done
);
  import bfp_pkg::*;

  function automatic logic [BW-1:0] blk_of(input logic [AW-1:0] a);
    return a[AW-1:BLK_AW];
  endfunction

  function automatic logic on_boundary(input logic [AW-1:0] a);
    return a[IW-1:0] == '0;
  endfunction

  function automatic logic [AW-1:0] load_base(input logic [AW-1:0] b, input logic [OW-1:0] n);
    return b + (AW'(n) << IW);
  endfunction

  bfp_state_e     st;
  logic [AW-1:0]  base_q;
  logic [BW-1:0]  blk_q;
  logic [IW-1:0]  cnt_q;
  logic [OW-1:0]  loads_q;
  logic           exiting_q;
  logic           show_sr_q;

  // named internal events
  logic wr_idle, wr_setup, wr_fill, wr_prog;
  logic confirm_hit, ev_bad_seq, ev_prot_abort, ev_misalign, ev_open;
  logic ev_leave, ev_addr_err, ev_store, ev_full, ev_clear;
  logic sr_seq, sr_prog, sr_ovf, sr_prot;
  logic [7:0] sr;

  assign wr_idle  = bus_we && st == S_IDLE;
  assign wr_setup = bus_we && st == S_SETUP;
  assign wr_fill  = bus_we && st == S_FILL;
  assign wr_prog  = bus_we && st == S_PROG;

  assign confirm_hit   = wr_setup && bus_wdata == DW'(CONFIRM_OP);
  assign ev_bad_seq    = wr_setup && !confirm_hit;
  assign ev_prot_abort = confirm_hit && blk_prot[blk_of(bus_addr)];
  assign ev_misalign   = confirm_hit && !ev_prot_abort && !on_boundary(bus_addr);
  assign ev_open       = confirm_hit && !ev_prot_abort && on_boundary(bus_addr);

  assign ev_leave    = wr_fill && blk_of(bus_addr) != blk_q;
  assign ev_addr_err = wr_fill && !ev_leave && bus_addr != base_q;
  assign ev_store    = wr_fill && bus_addr == base_q;
  assign ev_full     = ev_store && cnt_q == IW'(BUF_WORDS - 1);
  assign ev_clear    = wr_idle && bus_wdata == DW'(CLR_OP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      base_q    <= '0;
      blk_q     <= '0;
      cnt_q     <= '0;
      loads_q   <= '0;
      exiting_q <= 1'b0;
      show_sr_q <= 1'b0;
      arr_start <= 1'b0;
      arr_base  <= '0;
      arr_len   <= '0;
    end else begin
      arr_start <= 1'b0;
      unique case (st)
        S_IDLE: if (wr_idle) begin
          if (bus_wdata == DW'(SETUP_OP))      st <= S_SETUP;
          else if (bus_wdata == DW'(RDSR_OP))  show_sr_q <= 1'b1;
          else if (bus_wdata == DW'(RDARR_OP)) show_sr_q <= 1'b0;
        end
        S_SETUP: if (ev_open) begin
          st      <= S_FILL;
          base_q  <= bus_addr;
          blk_q   <= blk_of(bus_addr);
          cnt_q   <= '0;
          loads_q <= '0;
        end else if (ev_prot_abort || ev_misalign) begin
          st        <= S_IDLE;
          show_sr_q <= 1'b1;
        end else if (ev_bad_seq) begin
          st        <= S_IDLE;
          show_sr_q <= 1'b0;
        end
        S_FILL: if (ev_full) begin
          st        <= S_PROG;
          arr_start <= 1'b1;
          arr_len   <= LW'(BUF_WORDS);
          arr_base  <= load_base(base_q, loads_q);
          exiting_q <= 1'b0;
          cnt_q     <= '0;
        end else if (ev_store) begin
          cnt_q <= cnt_q + 1'b1;
        end else if (ev_leave) begin
          if (cnt_q != '0) begin
            st        <= S_PROG;
            arr_start <= 1'b1;
            arr_len   <= LW'(cnt_q);
            arr_base  <= load_base(base_q, loads_q);
            exiting_q <= 1'b1;
            cnt_q     <= '0;
          end else begin
            st        <= S_IDLE;
            show_sr_q <= 1'b0;
          end
        end else if (ev_addr_err) begin
          st        <= S_IDLE;
          show_sr_q <= 1'b1;
        end
        S_PROG: if (arr_done) begin
          if (exiting_q) begin
            st        <= S_IDLE;
            show_sr_q <= 1'b0;
          end else begin
            st      <= S_FILL;
            loads_q <= loads_q + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  bfp_wbuf #(.DW(DW), .DEPTH(BUF_WORDS)) u_wbuf (
    .clk   (clk),
    .we    (ev_store),
    .waddr (cnt_q),
    .wdata (bus_wdata),
    .raddr (arr_idx),
    .rdata (arr_word)
  );

  bfp_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_seq  (ev_bad_seq),
    .set_prog (ev_prot_abort || ev_misalign || ev_addr_err),
    .set_ovf  (wr_prog),
    .set_prot (ev_prot_abort),
    .clr      (ev_clear),
    .sr_seq   (sr_seq),
    .sr_prog  (sr_prog),
    .sr_ovf   (sr_ovf),
    .sr_prot  (sr_prot)
  );

  always_comb begin
    sr = '0;
    sr[SR_READY] = st != S_PROG;
    sr[SR_SEQ]   = sr_seq;
    sr[SR_PROG]  = sr_prog;
    sr[SR_OVF]   = sr_ovf;
    sr[SR_PROT]  = sr_prot;
  end

  assign bus_rdata = !bus_re ? '0 :
                     (st != S_IDLE || show_sr_q) ? {{(DW-8){1'b0}}, sr} : arr_rdata;

  // assertions
  assert_bad_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_seq |=> (sr_seq && (!bus_re || bus_rdata == arr_rdata)));

  assert_protect_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prot_abort |=> (sr_prog && sr_prot && !arr_start));

  assert_misalign_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_misalign |=> (sr_prog && !arr_start));

  assert_full_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full |=> (arr_start && arr_len == LW'(BUF_WORDS)));

  assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> (!bus_re || !bus_rdata[SR_READY]));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prog |=> sr_ovf);

  assert_clear_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> (!sr_prog && !sr_seq && !sr_ovf && !sr_prot));

  assert_addr_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_err |=> (sr_prog && !arr_start));
endmodule

// File: tb/bfp_ctrl_bench.sv
`timescale 1ns/100ps
module bfp_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b1;
  logic [15:0] bus_rdata;
  logic [15:0] arr_rdata = 16'hC3C3;
  logic [63:0] blk_prot = 64'h0000_0000_0000_0004;
  logic        arr_start;
  logic [15:0] arr_base;
  logic [5:0]  arr_len;
  logic [4:0]  arr_idx = '0;
  logic [15:0] arr_word;
  logic        arr_done = 1'b0;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int cycles = 0;
  logic [15:0] cap_base;
  int          cap_len;
  logic [15:0] cap [32];

  always #2 clk = ~clk;

  bfp_ctrl u_bfp_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .arr_rdata(arr_rdata),
    .blk_prot(blk_prot), .arr_start(arr_start), .arr_base(arr_base), .arr_len(arr_len),
    .arr_idx(arr_idx), .arr_word(arr_word), .arr_done(arr_done)
  );

  // behavioural array: pulls the buffer by index, then reports completion
  initial begin
    forever begin
      @(negedge clk);
      if (arr_start) begin
        starts++;
        cap_base = arr_base;
        cap_len  = int'(arr_len);
        for (int i = 0; i < cap_len; i++) begin
          arr_idx = 5'(i);
          #1;
          cap[i] = arr_word;
        end
        repeat (4) @(negedge clk);
        arr_done = 1'b1;
        @(negedge clk);
        arr_done = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (bus_rdata[7]) break;
    end
  endtask

  function automatic logic [15:0] word_of(input int load, input int k);
    if (load == 0 && k == 0) return 16'h0070;
    if (load == 0 && k == 1) return 16'h00B0;
    if (load == 0 && k == 2) return 16'h00FF;
    return 16'(load * 16'h1000 + k * 3 + 16'h0100);
  endfunction

  task automatic check_capture(input string req, input logic [15:0] base, input int len, input int load);
    check(cap_base == base, req, cap_base, base);
    check(cap_len == len, req, cap_len, len);
    for (int k = 0; k < len; k++)
      if (cap[k] != word_of(load, k)) check(1'b0, req, cap[k], word_of(load, k));
  endtask

  task automatic clear_all();
    wr(16'h0000, 16'h0050);
    wr(16'h0000, 16'h00FF);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(bus_rdata == 16'hC3C3, "R11 reset array mode", bus_rdata, 16'hC3C3);
    bus_re = 1'b0;
    @(negedge clk);
    check(bus_rdata == 16'h0000, "R11 no read strobe", bus_rdata, 0);
    bus_re = 1'b1;
  endtask

  task automatic t_bad_sequence();
    wr(16'h0400, 16'h0080);
    check(bus_rdata == 16'h0080, "R1 status after setup", bus_rdata, 16'h0080);
    wr(16'h0400, 16'h0033);
    check(bus_rdata == 16'hC3C3, "R2 back to array", bus_rdata, 16'hC3C3);
    wr(16'h0000, 16'h0070);
    check(bus_rdata == 16'h00A0, "R2 seq error bit", bus_rdata, 16'h00A0);
    wr(16'h0000, 16'h00FF);
    wr(16'h0000, 16'h0070);
    check(bus_rdata == 16'h00A0, "R10 sticky", bus_rdata, 16'h00A0);
    wr(16'h0000, 16'h0050);
    check(bus_rdata == 16'h0080, "R10 clear", bus_rdata, 16'h0080);
    wr(16'h0000, 16'h00FF);
    check(bus_rdata == 16'hC3C3, "R11 read array opcode", bus_rdata, 16'hC3C3);
    check(starts == 0, "R2 no request", starts, 0);
  endtask

  task automatic t_full_session();
    int s0 = starts;
    wr(16'h0400, 16'h0080);
    wr(16'h0400, 16'h00D0);
    check(bus_rdata == 16'h0080, "R1 status after confirm", bus_rdata, 16'h0080);
    for (int k = 0; k < 31; k++) wr(16'h0400, word_of(0, k));
    check(bus_rdata == 16'h0080, "R3 opcodes taken as data", bus_rdata, 16'h0080);
    check(starts == s0, "R6 no early request", starts, s0);
    wr(16'h0400, word_of(0, 31));
    check(bus_rdata[7] == 1'b0, "R6 busy after 32nd word", bus_rdata, 16'h0000);
    wr(16'h0400, 16'hDEAD);
    wait_ready();
    check(bus_rdata == 16'h0088, "R8 overflow sticky", bus_rdata, 16'h0088);
    check(starts == s0 + 1, "R6 one request", starts, s0 + 1);
    check_capture("R3 R6 first buffer", 16'h0400, 32, 0);
    for (int k = 0; k < 32; k++) wr(16'h0400, word_of(1, k));
    wait_ready();
    check(starts == s0 + 2, "R7 reload request", starts, s0 + 2);
    check_capture("R7 second buffer", 16'h0420, 32, 1);
    for (int k = 0; k < 5; k++) wr(16'h0400, word_of(2, k));
    wr(16'h0800, 16'h1234);
    wait_ready();
    check(starts == s0 + 3, "R9 flush request", starts, s0 + 3);
    check_capture("R9 partial buffer", 16'h0440, 5, 2);
    check(bus_rdata == 16'hC3C3, "R9 array mode after exit", bus_rdata, 16'hC3C3);
    wr(16'h0000, 16'h0070);
    check(bus_rdata == 16'h0088, "R10 overflow kept", bus_rdata, 16'h0088);
    clear_all();
  endtask

  task automatic t_exit_empty();
    int s0 = starts;
    wr(16'h0400, 16'h0080);
    wr(16'h0400, 16'h00D0);
    wr(16'h0C00, 16'h0000);
    check(bus_rdata == 16'hC3C3, "R9 empty exit", bus_rdata, 16'hC3C3);
    check(starts == s0, "R9 no request when empty", starts, s0);
  endtask

  task automatic t_misaligned();
    int s0 = starts;
    wr(16'h0405, 16'h0080);
    wr(16'h0405, 16'h00D0);
    check(bus_rdata == 16'h0090, "R4 misaligned", bus_rdata, 16'h0090);
    repeat (3) @(negedge clk);
    check(starts == s0, "R4 no request", starts, s0);
    clear_all();
  endtask

  task automatic t_protected();
    int s0 = starts;
    wr(16'h0800, 16'h0080);
    wr(16'h0800, 16'h00D0);
    check(bus_rdata == 16'h0092, "R5 protected", bus_rdata, 16'h0092);
    wr(16'h0800, 16'h0055);
    repeat (3) @(negedge clk);
    check(starts == s0, "R5 array untouched", starts, s0);
    clear_all();
  endtask

  task automatic t_addr_change();
    int s0 = starts;
    wr(16'h0400, 16'h0080);
    wr(16'h0400, 16'h00D0);
    wr(16'h0400, 16'h1111);
    wr(16'h0400, 16'h2222);
    wr(16'h0401, 16'h3333);
    check(bus_rdata == 16'h0090, "R12 address change", bus_rdata, 16'h0090);
    repeat (3) @(negedge clk);
    check(starts == s0, "R12 no request", starts, s0);
    clear_all();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bad_sequence();
    t_full_session();
    t_exit_empty();
    t_misaligned();
    t_protected();
    t_addr_change();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule